// File: doc/BRIEF.md
# Primary Clock Failure Monitor

This block watches the primary system clock from a separate, always-running reference clock. When the primary clock is missing at the start of monitoring, or stops while monitoring runs, it forces the system clock selection over to the internal fast RC oscillator. At the same time it raises a one-cycle trap request and a sticky fail flag, so software can later move back to the wanted oscillator.

Monitoring begins only after the reset sequencer reports that reset has been released. For crystal or PLL sources it is held off further, until the sequencer's settling-delay-expired input is high. That delay is nominally around 100 microseconds and gives the oscillator or PLL time to settle.

Presence is judged window by window. The primary clock is first divided by 2^`DIV_LOG2` in its own domain. Each toggle of the divided clock is brought into the reference domain and counted as one primary event. A window of `WIN_CYC` reference cycles that holds fewer than `MIN_EDGES` events counts as a failure. With the default of 1, this means a window with zero events. The fail state then stays latched until `fail_clear` or a new reset. When the monitor enable is low, the block never switches and never traps. All control and status pins are plain level or pulse signals with no handshake.

Top module: `cfm_top`

## Requirements
- R1: While `rst_n` is low and on the first sample after it rises, `sel_rc`, `trap_req` and `fail_flag` are all 0.
- R2: Before the first `rst_release` pulse after reset, no failure is reported, even with `mon_en` high and the primary clock stopped.
- R3: With `xtal_class` low, monitoring starts on `rst_release`. A primary clock that never runs is reported between `WIN_CYC` and `WIN_CYC`+4 reference cycles after the release pulse.
- R4: With `xtal_class` high, no failure is reported while `settle_done` is low. Once `settle_done` rises, a dead primary clock is reported within `WIN_CYC`+4 cycles.
- R5: A running primary clock with a period between 0.6 and 4 reference periods is never reported as failed.
- R6: When a running primary clock stops at any point, the failure is reported within 2×`WIN_CYC`+6 reference cycles.
- R7: On a failure, `sel_rc` and `fail_flag` rise in the same cycle. `trap_req` is high for exactly that one cycle, giving one trap pulse per failure.
- R8: After a failure, `sel_rc` and `fail_flag` stay high until `fail_clear` or reset, even if the primary clock comes back.
- R9: `fail_clear` drops `sel_rc` and `fail_flag` on the next cycle. Monitoring then restarts with a fresh window, so a still-dead primary clock is reported again no sooner than `WIN_CYC` cycles later.
- R10: While `mon_en` is low, no switch, trap or fail flag is produced, even when the primary clock stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Internal reference clock; all monitor logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| prim_clk | input | 1 | Primary system clock being watched |
| mon_en | input | 1 | Monitor enable |
| rst_release | input | 1 | One-cycle pulse from the reset sequencer when reset is released |
| xtal_class | input | 1 | 1 = crystal or PLL source (needs settling delay), 0 = other |
| settle_done | input | 1 | Extra settling delay has expired |
| fail_clear | input | 1 | Clears the latched failure and restarts monitoring |
| sel_rc | output | 1 | 1 = select internal fast RC oscillator |
| trap_req | output | 1 | One-cycle clock-fail trap request |
| fail_flag | output | 1 | Sticky failure status |

## Verification
The hardest case to reach from the ports is a primary clock that stops at an arbitrary phase of the detection window. A divided toggle may still be travelling through the synchronizer at that moment, and it can be credited to the window that is already running. To cover this, the bench restarts a healthy clock and clears the fault. It then steps the stop point across every reference-cycle offset within one window and, for each offset, checks the bounded detection latency and the single trap pulse. Separate sweeps run the clock at several healthy periods, hold it stopped before release or while the settling delay is pending, and hold it stopped with the monitor disabled.

// File: rtl/cfm_pkg.sv
package cfm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_WATCH  = 2'd2,
    ST_FAILED = 2'd3
  } cfm_state_e;
endpackage

// File: rtl/cfm_prim_div.sv
// Primary-domain divider: toggles an event bit every 2^DIV_LOG2 edges.
module cfm_prim_div #(
  parameter int DIV_LOG2 = 1
) (
  input  logic prim_clk,
  input  logic rst_n,
  output logic tog
);
  logic [DIV_LOG2-1:0] div_cnt;

  always_ff @(posedge prim_clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      tog     <= 1'b0;
    end else begin
      div_cnt <= div_cnt + 1'b1;
      if (&div_cnt) tog <= ~tog;
    end
  end
endmodule

// File: rtl/cfm_sync_edge.sv
// Brings the primary toggle into the reference domain, pulses per change.
module cfm_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic tog_in,
  output logic evt
);
  logic [STAGES:0] pipe;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-1:0], tog_in};
  end

  assign evt = pipe[STAGES] ^ pipe[STAGES-1];
endmodule

// File: rtl/cfm_window.sv
// Counts primary events over fixed windows of reference cycles.
module cfm_window #(
  parameter int WIN_CYC   = 16,
  parameter int MIN_EDGES = 1
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic run,
  input  logic evt,
  output logic win_dead
);
  localparam int WIN_W = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
  localparam int EVT_W = $clog2(MIN_EDGES + 1) + 1;
  localparam logic [WIN_W-1:0] LAST = WIN_W'(WIN_CYC - 1);
  localparam logic [EVT_W-1:0] SAT  = EVT_W'(MIN_EDGES);

  logic [WIN_W-1:0] cyc_q;
  logic [EVT_W-1:0] evt_q, evt_sum;
  logic             at_end;

  assign at_end  = (cyc_q == LAST);
  assign evt_sum = (evt && (evt_q < SAT)) ? evt_q + 1'b1 : evt_q;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
      evt_q <= '0;
    end else if (!run || at_end) begin
      cyc_q <= '0;
      evt_q <= '0;
    end else begin
      cyc_q <= cyc_q + 1'b1;
      evt_q <= evt_sum;
    end
  end

  assign win_dead = run && at_end && (evt_sum < SAT);
endmodule

// File: rtl/cfm_ctrl.sv
// Sequencing of arm, hold-off, watch and latched failure.
module cfm_ctrl
  import cfm_pkg::*;
(
  input  logic ref_clk,
  input  logic rst_n,
  input  logic mon_en,
  input  logic rst_release,
  input  logic xtal_class,
  input  logic settle_done,
  input  logic fail_clear,
  input  logic win_dead,
  output logic watching,
  output logic sel_rc,
  output logic trap_req,
  output logic fail_flag
);
  cfm_state_e st_q, st_d;
  logic       go_fail;

  always_comb begin
    st_d    = st_q;
    go_fail = 1'b0;
    unique case (st_q)
      ST_IDLE:   if (rst_release) st_d = ST_ARMED;
      ST_ARMED:  if (mon_en && (!xtal_class || settle_done)) st_d = ST_WATCH;
      ST_WATCH: begin
        if (!mon_en || fail_clear) st_d = ST_ARMED;
        else if (win_dead) begin
          st_d    = ST_FAILED;
          go_fail = 1'b1;
        end
      end
      ST_FAILED: if (fail_clear) st_d = ST_ARMED;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      sel_rc    <= 1'b0;
      trap_req  <= 1'b0;
      fail_flag <= 1'b0;
    end else begin
      st_q     <= st_d;
      trap_req <= go_fail;
      if (go_fail) begin
        sel_rc    <= 1'b1;
        fail_flag <= 1'b1;
      end else if (fail_clear) begin
        sel_rc    <= 1'b0;
        fail_flag <= 1'b0;
      end
    end
  end

  assign watching = (st_q == ST_WATCH);
endmodule

// File: rtl/cfm_top.sv
module cfm_top #(
  parameter int WIN_CYC     = 16,
  parameter int MIN_EDGES   = 1,
  parameter int DIV_LOG2    = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic prim_clk,
  input  logic mon_en,
  input  logic rst_release,
  input  logic xtal_class,
  input  logic settle_done,
  input  logic fail_clear,
  output logic sel_rc,
  output logic trap_req,
  output logic fail_flag
);
  logic prim_tog, prim_evt, watching, win_dead;

  cfm_prim_div #(.DIV_LOG2(DIV_LOG2)) u_div (
    .prim_clk(prim_clk), .rst_n(rst_n), .tog(prim_tog)
  );

  cfm_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .ref_clk(ref_clk), .rst_n(rst_n), .tog_in(prim_tog), .evt(prim_evt)
  );

  cfm_window #(.WIN_CYC(WIN_CYC), .MIN_EDGES(MIN_EDGES)) u_win (
    .ref_clk(ref_clk), .rst_n(rst_n), .run(watching), .evt(prim_evt),
    .win_dead(win_dead)
  );

  cfm_ctrl u_ctrl (
    .ref_clk(ref_clk), .rst_n(rst_n), .mon_en(mon_en),
    .rst_release(rst_release), .xtal_class(xtal_class),
    .settle_done(settle_done), .fail_clear(fail_clear),
    .win_dead(win_dead), .watching(watching), .sel_rc(sel_rc),
    .trap_req(trap_req), .fail_flag(fail_flag)
  );
endmodule

// File: rtl/cfm_checker.sv
module cfm_checker (
  input logic ref_clk,
  input logic rst_n,
  input logic mon_en,
  input logic rst_release,
  input logic fail_clear,
  input logic sel_rc,
  input logic trap_req,
  input logic fail_flag
);
  logic rel_seen;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)           rel_seen <= 1'b0;
    else if (rst_release) rel_seen <= 1'b1;
  end

  // R2: no failure before release
  a_r2_no_fail_before_release: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !rel_seen |-> !fail_flag);

  // R7: trap lasts one cycle
  a_r7_trap_single: assert property (@(posedge ref_clk) disable iff (!rst_n)
    trap_req |=> !trap_req);

  // R7: flag rise comes with trap and RC selection
  a_r7_rise_with_trap: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(fail_flag) |-> (trap_req && sel_rc));

  // R8: latched until cleared
  a_r8_latched: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (fail_flag && !fail_clear) |=> (fail_flag && sel_rc));

  // R9: clear drops status next cycle
  a_r9_clear: assert property (@(posedge ref_clk) disable iff (!rst_n)
    fail_clear |=> (!fail_flag && !sel_rc));

  // R10: disabled monitor never starts a failure
  a_r10_disabled: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!mon_en && !fail_flag) |=> (!fail_flag && !trap_req));
endmodule

bind cfm_top cfm_checker u_cfm_chk (
  .ref_clk(ref_clk), .rst_n(rst_n), .mon_en(mon_en),
  .rst_release(rst_release), .fail_clear(fail_clear),
  .sel_rc(sel_rc), .trap_req(trap_req), .fail_flag(fail_flag)
);

// File: tb/tb_cfm_top.sv
`timescale 1ns/1ps
module tb_cfm_top;
  localparam int WIN = 16;

  logic ref_clk = 1'b0, rst_n = 1'b0, prim_clk = 1'b0;
  logic mon_en = 1'b0, rst_release = 1'b0, xtal_class = 1'b0;
  logic settle_done = 1'b0, fail_clear = 1'b0;
  logic sel_rc, trap_req, fail_flag;

  logic    prim_run = 1'b0;
  realtime prim_half = 7.0;
  int n_chk = 0, n_fail = 0, trap_cnt = 0, lat;

  cfm_top #(.WIN_CYC(WIN)) dut (
    .ref_clk(ref_clk), .rst_n(rst_n), .prim_clk(prim_clk), .mon_en(mon_en),
    .rst_release(rst_release), .xtal_class(xtal_class),
    .settle_done(settle_done), .fail_clear(fail_clear),
    .sel_rc(sel_rc), .trap_req(trap_req), .fail_flag(fail_flag)
  );

  always #5 ref_clk = ~ref_clk;

  initial forever begin
    #(prim_half);
    if (prim_run) prim_clk = ~prim_clk;
    else          prim_clk = 1'b0;
  end

  always @(negedge ref_clk) if (trap_req) trap_cnt++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge ref_clk);
  endtask

  task automatic wait_fail(input int maxc, output int l);
    l = 0;
    while (!fail_flag && l < maxc) begin
      @(negedge ref_clk);
      l++;
    end
  endtask

  task automatic pulse_release();
    rst_release = 1'b1; tick(1); rst_release = 1'b0;
  endtask

  task automatic pulse_clear();
    fail_clear = 1'b1; tick(1); fail_clear = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick(3); rst_n = 1'b1; tick(1);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int t0;
    tick(2);
    // R1: outputs low during and after reset
    check(!sel_rc && !trap_req && !fail_flag, "R1 in reset", {sel_rc, trap_req, fail_flag}, 0);
    rst_n = 1'b1; tick(1);
    check(!sel_rc && !trap_req && !fail_flag, "R1 after reset", {sel_rc, trap_req, fail_flag}, 0);

    // R2: enabled, dead clock, no release yet
    mon_en = 1'b1;
    tick(4 * WIN);
    check(!fail_flag && trap_cnt == 0, "R2 before release", fail_flag, 0);

    // R3: release with dead clock, non-crystal class
    pulse_release();
    wait_fail(4 * WIN, lat);
    check(lat >= WIN && lat <= WIN + 4, "R3 detect latency", lat, WIN + 2);
    // R7: status and trap together, then trap drops
    check(sel_rc && trap_req && fail_flag, "R7 status at fail", {sel_rc, trap_req, fail_flag}, 7);
    tick(1);
    check(!trap_req, "R7 trap one cycle", trap_req, 0);

    // R8: clock returns, failure stays latched
    prim_half = 7.0; prim_run = 1'b1;
    tick(4 * WIN);
    check(fail_flag && sel_rc, "R8 latched", {sel_rc, fail_flag}, 3);

    // R9: clear drops status
    pulse_clear();
    check(!fail_flag && !sel_rc, "R9 clear", {sel_rc, fail_flag}, 0);

    // R5: healthy period sweep (0.6 .. 3.7 ref periods)
    foreach (prim_half_list[i]) begin
      prim_half = prim_half_list[i];
      tick(6 * WIN);
      check(!fail_flag, $sformatf("R5 healthy half %0.1f", prim_half), fail_flag, 0);
    end
    check(trap_cnt == 1, "R7 trap count healthy", trap_cnt, 1);

    // R6: stop at every offset within one window
    prim_half = 7.0;
    for (int off = 0; off < WIN; off++) begin
      tick(off);
      prim_run = 1'b0;
      wait_fail(4 * WIN, lat);
      check(fail_flag && lat >= 1 && lat <= 2 * WIN + 6, $sformatf("R6 stop offset %0d", off), lat, 2 * WIN);
      prim_run = 1'b1;
      tick(3);
      pulse_clear();
      tick(2 * WIN);
    end
    check(trap_cnt == 1 + WIN, "R7 one trap per failure", trap_cnt, 1 + WIN);
    check(!fail_flag, "R5 healthy after sweep", fail_flag, 0);

    // R9: clear while clock still dead, refail after fresh window
    prim_run = 1'b0;
    wait_fail(4 * WIN, lat);
    pulse_clear();
    check(!fail_flag, "R9 clear while dead", fail_flag, 0);
    wait_fail(4 * WIN, lat);
    check(fail_flag && lat >= WIN, "R9 fresh window", lat, WIN + 2);

    // R1: reset clears latched failure
    do_reset();
    check(!fail_flag && !sel_rc, "R1 reset clears", {sel_rc, fail_flag}, 0);

    // R10: disabled, clock dead, released
    t0 = trap_cnt;
    mon_en = 1'b0;
    pulse_release();
    tick(6 * WIN);
    check(!fail_flag && !sel_rc && trap_cnt == t0, "R10 disabled", trap_cnt - t0, 0);
    // R10: enable later starts monitoring
    mon_en = 1'b1;
    wait_fail(4 * WIN, lat);
    check(fail_flag, "R10 enable resumes", fail_flag, 1);

    // R4: crystal class hold-off
    do_reset();
    xtal_class = 1'b1; settle_done = 1'b0;
    pulse_release();
    tick(6 * WIN);
    check(!fail_flag, "R4 held off", fail_flag, 0);
    settle_done = 1'b1;
    wait_fail(4 * WIN, lat);
    check(fail_flag && lat <= WIN + 4, "R4 after settle", lat, WIN + 2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  realtime prim_half_list [5] = '{3.0, 4.5, 7.0, 11.5, 18.5};
endmodule